// File: doc/BRIEF.md
# T1 Transmit System-Side Timing Generator

This block drives the transmit system interface of a single T1/J1 link when the link is the timing master. An external strobe, `half_tick`, comes twice per bit period. The block alternates between two phases of each bit slot, phase 0 and phase 1. From these it produces three things:

- a bit enable (`bit_en`) that takes the place of the system clock;
- a frame pulse (`fp`);
- position counters for channel, bit and frame.

On each enabled slot the block captures one payload bit (`sd`) and one signaling bit (`ssig`). Gaps in the clock are modelled as missing enables, so the clock itself is never gated.

A frame has 193 slots. Slot 0 is the F-bit. Channels 1 to 24 follow, eight bits each, sent most significant bit first. In full mode every slot is enabled. In fractional mode the enable is withheld in two cases:

- for the whole of a channel that is not selected;
- for only bit 8 of a channel that carries 56 kb/s payload.

The frame pulse has three options. It can mark every F-bit or only the F-bit of multiframe frame 0. Its polarity can be inverted. Its update phase and the data sample phase are chosen independently, so the pulse can lead the sampling by half a bit.

Top module: `t1_tx_sys_timing`

## Requirements
- R1: With `frac_mode`=0, every slot of the 193-slot frame produces exactly one `bit_en` pulse, whatever `ch_sel` and `ch_56k` hold.
- R2: With `frac_mode`=1, channel c (1..24) is enabled only if `ch_sel[c-1]`=1. No `bit_en` is issued in an unselected channel, and `sd`/`ssig` offered there leave `pay_data`/`pay_sig` unchanged.
- R3: With `frac_mode`=1, a selected channel c with `ch_56k[c-1]`=1 loses only its bit 8 (`bit_idx`=7). The F-bit is always enabled.
- R4: With `mf_mark`=0 the frame pulse is active for the F-bit slot of every frame. With `mf_mark`=1 it is active only for the F-bit of frame 0 of the multiframe.
- R5: `fp` is the internal pulse XOR `fp_inv`. After reset, and whenever inactive, `fp` equals `fp_inv`.
- R6: `fp` is updated on the half-tick whose phase equals `fp_edge`, and data is sampled on the half-tick whose phase equals `smp_edge`. When the two differ, `fp` announces a slot one half-tick before that slot is sampled. When they are equal, both happen on the same half-tick.
- R7: `sd` and `ssig` are captured together on the sampling half-tick of an enabled slot. `bit_en`, `pay_data` and `pay_sig` change in the clock after that half-tick.
- R8: `ch_idx` is 0 on the F-bit and 1..24 in the channels. `bit_idx` counts 0..7 within a channel. Both advance after each phase-1 half-tick. Slot s>0 is channel (s-1)/8+1, bit (s-1)%8.
- R9: `frm_idx` counts frames 0..11 when `esf`=0 and 0..23 when `esf`=1, then wraps to 0.
- R10: After reset `bit_en`=0 and `ch_idx`, `bit_idx`, `frm_idx` are all 0, with the phase at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Strobe at twice the 1.544 Mb/s bit rate |
| frac_mode | input | 1 | 1 = fractional (gapped) mode |
| ch_sel | input | 24 | Bit c-1 selects channel c |
| ch_56k | input | 24 | Bit c-1 drops bit 8 of channel c |
| mf_mark | input | 1 | 1 = pulse only at multiframe start |
| fp_inv | input | 1 | Frame pulse polarity inversion |
| esf | input | 1 | 0 = 12-frame, 1 = 24-frame multiframe |
| fp_edge | input | 1 | Phase that updates the frame pulse |
| smp_edge | input | 1 | Phase that samples data and signaling |
| sd | input | 1 | Serial payload in |
| ssig | input | 1 | Serial signaling in |
| bit_en | output | 1 | Bit enable (stands in for the system clock) |
| fp | output | 1 | Frame pulse |
| pay_data | output | 1 | Last captured payload bit |
| pay_sig | output | 1 | Last captured signaling bit |
| ch_idx | output | 5 | Current channel, 0 = F-bit |
| bit_idx | output | 3 | Bit within channel |
| frm_idx | output | 5 | Frame within multiframe |

## Verification
Every result arrives exactly one clock after the half-tick that causes it:

- `bit_en`, `pay_data` and `pay_sig` follow the sampling half-tick;
- `fp` follows the frame-pulse half-tick;
- the counters follow a phase-1 half-tick.

The bench raises each half-tick at a falling clock edge and lowers it at the next falling edge. It checks the outputs at that second falling edge, which is after the single rising edge that registers them.

The bench keeps its own slot, phase and frame model. From that model it predicts four things at every half-tick:

- whether an enable is due;
- the captured bits;
- the held value through gaps;
- the expected frame pulse level.

It also counts enables and pulses per frame against hand-computed totals.

// File: rtl/t1_tx_sys_timing.sv
module t1_tx_sys_timing #(
  parameter int NUM_CH     = 24,
  parameter int CH_BITS    = 8,
  parameter int SF_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  localparam int CW = $clog2(NUM_CH + 1),
  localparam int BW = $clog2(CH_BITS),
  localparam int FW = $clog2(ESF_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              frac_mode,
  input  logic [NUM_CH-1:0] ch_sel,
  input  logic [NUM_CH-1:0] ch_56k,
  input  logic              mf_mark,
  input  logic              fp_inv,
  input  logic              esf,
  input  logic              fp_edge,
  input  logic              smp_edge,
  input  logic              sd,
  input  logic              ssig,
  output logic              bit_en,
  output logic              fp,
  output logic              pay_data,
  output logic              pay_sig,
  output logic [CW-1:0]     ch_idx,
  output logic [BW-1:0]     bit_idx,
  output logic [FW-1:0]     frm_idx
);

  logic          ph;
  logic          fp_raw;
  logic [CW-1:0] ch;
  logic [BW-1:0] bt;
  logic [FW-1:0] frm;

  wire [FW-1:0] frm_last  = esf ? FW'(ESF_FRAMES - 1) : FW'(SF_FRAMES - 1);
  wire [FW-1:0] frm_nxt   = (frm >= frm_last) ? '0 : frm + 1'b1;
  wire [CW-1:0] ch_m1     = ch - 1'b1;
  wire          is_f      = (ch == '0);
  wire          last_bit  = (bt == BW'(CH_BITS - 1));
  wire          last_slot = (ch == CW'(NUM_CH)) && last_bit;

  wire gap      = frac_mode && !is_f && (!ch_sel[ch_m1] || (ch_56k[ch_m1] && last_bit));
  wire smp_ev   = half_tick && (ph == smp_edge);
  wire fp_ev    = half_tick && (ph == fp_edge);
  wire look     = (fp_edge != smp_edge) && ph;
  wire mark_now = is_f && (!mf_mark || frm == '0);
  wire mark_nxt = last_slot && (!mf_mark || frm_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= 1'b0;
      ch       <= '0;
      bt       <= '0;
      frm      <= '0;
      fp_raw   <= 1'b0;
      bit_en   <= 1'b0;
      pay_data <= 1'b0;
      pay_sig  <= 1'b0;
    end else begin
      bit_en <= smp_ev && !gap;
      if (smp_ev && !gap) begin
        pay_data <= sd;
        pay_sig  <= ssig;
      end
      if (fp_ev) fp_raw <= look ? mark_nxt : mark_now;
      if (half_tick) begin
        ph <= ~ph;
        if (ph) begin
          if (is_f) begin
            ch <= CW'(1);
            bt <= '0;
          end else if (last_bit) begin
            bt <= '0;
            if (ch == CW'(NUM_CH)) begin
              ch  <= '0;
              frm <= frm_nxt;
            end else begin
              ch <= ch + 1'b1;
            end
          end else begin
            bt <= bt + 1'b1;
          end
        end
      end
    end
  end

  assign fp      = fp_raw ^ fp_inv;
  assign ch_idx  = ch;
  assign bit_idx = bt;
  assign frm_idx = frm;

  // R1
  full_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && ph == smp_edge && !frac_mode) |=> bit_en);

  // R2
  unsel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && frac_mode && ch != '0 && !ch_sel[ch_m1]) |=> !bit_en);

  // R3
  bit8_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && frac_mode && ch != '0 && ch_56k[ch_m1] && bt == BW'(CH_BITS - 1)) |=> !bit_en);

  // R3
  fbit_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && ph == smp_edge && ch == '0) |=> bit_en);

  // R7
  en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> $past(half_tick));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> ($stable(pay_data) && $stable(pay_sig)));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch <= CW'(NUM_CH)) && (ch != '0 || bt == '0));

  // R9
  frm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm < FW'(ESF_FRAMES));

endmodule

// File: tb/sim_t1_tx_sys_timing.sv
module sim_t1_tx_sys_timing;

  typedef struct packed {
    logic        frac;
    logic [23:0] sel;
    logic [23:0] k56;
    logic        mf;
    logic        inv;
    logic        fe;
    logic        de;
    logic [7:0]  cnt;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{1'b0, 24'h000000, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 8'd193},
    '{1'b1, 24'hFFFFFF, 24'h000000, 1'b0, 1'b1, 1'b0, 1'b1, 8'd193},
    '{1'b1, 24'h000FFF, 24'h000000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd97},
    '{1'b1, 24'hFFFFFF, 24'hFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 8'd169},
    '{1'b1, 24'h0000FF, 24'h00000F, 1'b1, 1'b1, 1'b0, 1'b1, 8'd61},
    '{1'b1, 24'h800001, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd17}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, half_tick = 1'b0, frac_mode = 1'b0;
  logic [23:0] ch_sel = '0, ch_56k = '0;
  logic        mf_mark = 1'b0, fp_inv = 1'b0, esf = 1'b0, fp_edge = 1'b0, smp_edge = 1'b0;
  logic        sd = 1'b0, ssig = 1'b0;
  logic        bit_en, fp, pay_data, pay_sig;
  logic [4:0]  ch_idx, frm_idx;
  logic [2:0]  bit_idx;

  t1_tx_sys_timing u0 (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .frac_mode(frac_mode),
    .ch_sel(ch_sel), .ch_56k(ch_56k), .mf_mark(mf_mark), .fp_inv(fp_inv),
    .esf(esf), .fp_edge(fp_edge), .smp_edge(smp_edge), .sd(sd), .ssig(ssig),
    .bit_en(bit_en), .fp(fp), .pay_data(pay_data), .pay_sig(pay_sig),
    .ch_idx(ch_idx), .bit_idx(bit_idx), .frm_idx(frm_idx)
  );

  int checks = 0, errors = 0;
  int bs, bf, n_en, n_fp, n_fp_exp, e_en, e_dat, e_fp;
  bit bph, last_d, last_s;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit dat_of(int s, int f);
    return ((s * 5 + f * 3) % 7) < 3;
  endfunction

  function automatic bit sig_of(int s, int f);
    return ((s + f) % 3) == 0;
  endfunction

  function automatic bit gap_m(int s);
    int c, b;
    if (!frac_mode || s == 0) return 1'b0;
    c = (s - 1) / 8 + 1;
    b = (s - 1) % 8;
    return !ch_sel[c-1] || (ch_56k[c-1] && b == 7);
  endfunction

  function automatic int last_frm();
    return esf ? 23 : 11;
  endfunction

  task automatic half();
    bit exp_en, exp_fp;
    int ts, tf;
    @(negedge clk);
    half_tick = 1'b1;
    sd = dat_of(bs, bf);
    ssig = sig_of(bs, bf);
    @(negedge clk);
    half_tick = 1'b0;
    sd = ~sd;
    ssig = ~ssig;
    exp_en = (bph == smp_edge) && !gap_m(bs);
    if (bit_en !== exp_en) e_en++;
    if (bit_en) n_en++;
    if (exp_en) begin
      last_d = dat_of(bs, bf);
      last_s = sig_of(bs, bf);
    end
    if (pay_data !== last_d || pay_sig !== last_s) e_dat++;
    if (bph == fp_edge) begin
      ts = bs; tf = bf;
      if (fp_edge != smp_edge && bph) begin
        ts = bs + 1;
        if (ts == 193) begin
          ts = 0;
          tf = (bf >= last_frm()) ? 0 : bf + 1;
        end
      end
      exp_fp = (ts == 0) && (!mf_mark || tf == 0);
      if (fp !== (exp_fp ^ fp_inv)) e_fp++;
      if (exp_fp) n_fp_exp++;
      if (fp ^ fp_inv) n_fp++;
    end
    if (bph) begin
      bs++;
      if (bs == 193) begin
        bs = 0;
        bf = (bf >= last_frm()) ? 0 : bf + 1;
      end
    end
    bph = ~bph;
  endtask

  task automatic run(input int slots);
    repeat (2 * slots) half();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    half_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bs = 0; bf = 0; bph = 1'b0; last_d = 1'b0; last_s = 1'b0;
    n_en = 0; n_fp = 0; n_fp_exp = 0; e_en = 0; e_dat = 0; e_fp = 0;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    for (int i = 0; i < 6; i++) begin
      frac_mode = ROWS[i].frac; ch_sel = ROWS[i].sel; ch_56k = ROWS[i].k56;
      mf_mark = ROWS[i].mf; fp_inv = ROWS[i].inv; esf = 1'b0;
      fp_edge = ROWS[i].fe; smp_edge = ROWS[i].de;
      do_reset();
      // R10 reset state, R5 idle polarity
      chk(bit_en === 1'b0 && ch_idx === 5'd0 && bit_idx === 3'd0 && frm_idx === 5'd0,
          "R10", int'(ch_idx), 0);
      chk(fp === ROWS[i].inv, "R5", int'(fp), int'(ROWS[i].inv));
      run(193);
      tag = !ROWS[i].frac ? "R1" : (ROWS[i].k56 != 0 ? "R3" : "R2");
      chk(n_en == int'(ROWS[i].cnt), tag, n_en, int'(ROWS[i].cnt));
      chk(e_en == 0, tag, e_en, 0);
      // R7 capture of data and signaling, R2 hold through gaps
      chk(e_dat == 0, "R7", e_dat, 0);
      chk(e_fp == 0, (ROWS[i].fe != ROWS[i].de) ? "R6" : "R4", e_fp, 0);
      chk(n_fp == n_fp_exp, "R4", n_fp, n_fp_exp);
    end

    // R2: data in unselected channels is ignored; pay_data still holds ch12 bit 8
    frac_mode = 1'b1; ch_sel = 24'h000FFF; ch_56k = '0; mf_mark = 1'b0;
    fp_inv = 1'b0; fp_edge = 1'b0; smp_edge = 1'b0;
    do_reset();
    run(193);
    chk(pay_data === dat_of(96, 0) && pay_sig === sig_of(96, 0), "R2",
        int'(pay_data), int'(dat_of(96, 0)));

    // R8 counter position after 30 slots
    frac_mode = 1'b0;
    do_reset();
    run(30);
    chk(ch_idx === 5'd4 && bit_idx === 3'd5, "R8", int'(ch_idx) * 10 + int'(bit_idx), 45);

    // R9 SF multiframe, R4 single mark
    mf_mark = 1'b1; esf = 1'b0;
    do_reset();
    run(193 * 11);
    chk(frm_idx === 5'd11, "R9", int'(frm_idx), 11);
    run(193);
    chk(frm_idx === 5'd0 && ch_idx === 5'd0, "R9", int'(frm_idx), 0);
    chk(n_fp == 1 && e_fp == 0, "R4", n_fp, 1);

    // R9 ESF multiframe
    esf = 1'b1;
    do_reset();
    run(193 * 23);
    chk(frm_idx === 5'd23, "R9", int'(frm_idx), 23);
    run(193);
    chk(frm_idx === 5'd0, "R9", int'(frm_idx), 0);
    chk(n_fp == 1 && e_fp == 0, "R4", n_fp, 1);

    // R5 live polarity flip while idle
    fp_inv = 1'b1;
    @(negedge clk);
    chk(fp === 1'b1, "R5", int'(fp), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule